// File: doc/BRIEF.md
# Integer Condition and Exception Flag Unit

This block computes the integer status of a 32-bit processor and keeps it in two architectural registers. One operation per cycle, marked by a valid strobe, is one of: add, subtract, signed compare, unsigned compare, shift left or shift right. The second operand is either a register value or a 16-bit immediate. The unit registers the numeric result. It derives carry, signed overflow and the less-than, greater-than and equal conditions from that result.

The condition register is 32 bits wide and holds eight independent 4-bit fields. Arithmetic and shift results can be recorded into field 0. Compares write the field that the selector names. The exception register holds three flags and an 8-bit byte count:

- summary overflow, which is sticky;
- overflow, which reflects the last add or subtract;
- carry, which also takes the bit shifted out by a shift.

Software can overwrite either register through a dedicated write port. That write wins over any operation in the same cycle.

Top module: `cfx_flag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result_o`, `cr_o` and `xer_o` become zero.
- R2: Op code 0 (add) registers `result_o = a + b` modulo 2^32. It sets carry (`xer_o[2]`) to the carry out of bit 31.
- R3: Op code 1 (subtract) registers `result_o = a - b`. Carry is the carry out of `a + ~b + 1`, so it is 1 exactly when a >= b unsigned.
- R4: An add or subtract sets overflow (`xer_o[1]`) to 1 on signed overflow and to 0 otherwise. Signed overflow means:
  - for add, both operands have the same sign and the result sign differs;
  - for subtract, the operand signs differ and the result sign differs from a.
- R5: Summary overflow (`xer_o[0]`) becomes 1 on any add or subtract overflow. It then stays 1 until an explicit exception-register write clears it.
- R6: Op codes 4 (shift left) and 5 (logical shift right) shift a by b[4:0] and register the result.
  - Carry takes the last bit shifted out, or 0 for a zero shift amount.
  - Overflow and summary overflow are left unchanged.
- R7: With `record_i` high, add, subtract and shift write field 0 (`cr_o[3:0]`) as {LT, GT, EQ, SO} in bits 3..0:
  - LT is result negative, GT is result positive and nonzero, EQ is result zero;
  - SO is summary overflow including an overflow from the same operation.
  - With `record_i` low, `cr_o` is unchanged.
- R8: Op codes 2 (signed compare) and 3 (unsigned compare) write {LT, GT, EQ, SO} for a versus b into field k = `fsel_i`, at `cr_o[4k+3:4k]`.
  - All other fields, `result_o` and `xer_o` are unchanged.
  - Equal operands give EQ in both compares.
- R9: With `imm_sel_i` high, the 16-bit immediate replaces b. It is zero-extended for the unsigned compare and sign-extended for every other operation.
- R10: Operations change only `xer_o[2:0]`. The byte count `xer_o[31:24]` and the other bits change only through the explicit write.
- R11: Explicit register writes load their data on the next edge and take priority over any operation in the same cycle. The operation's result register still updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 signed cmp, 3 unsigned cmp, 4 shl, 5 shr) |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (register) |
| imm_i | input | 16 | Immediate second operand |
| imm_sel_i | input | 1 | Use the immediate instead of `opb_i` |
| record_i | input | 1 | Record arithmetic/shift status into field 0 |
| fsel_i | input | 3 | Target field of a compare |
| cr_we_i | input | 1 | Explicit condition-register write |
| cr_wdata_i | input | 32 | Condition-register write data |
| xer_we_i | input | 1 | Explicit exception-register write |
| xer_wdata_i | input | 32 | Exception-register write data |
| result_o | output | 32 | Registered arithmetic/shift result |
| cr_o | output | 32 | Condition register |
| xer_o | output | 32 | Exception register |

## Verification
The bench targets the two signed-overflow boundaries of each operation: 0x7FFFFFFF+1, and subtracting across the sign boundary. A design that checked only the operand signs would miss the subtract case, and one that used the carry would flag unsigned wraps. It runs shifts by 0 and by large amounts to catch a carry taken from the wrong bit. It also runs compares of 0xFFFFFFFF against 1 in both modes, where a design that ignored signedness writes the same field value twice. Finally, it drives explicit writes alongside an overflowing operation and checks that summary overflow survives a clean operation. A wrong priority or a non-sticky flag shows up as a stale or cleared bit 0 in the exception register and in field 0.

// File: rtl/cfx_pkg.sv
package cfx_pkg;

    localparam int XLEN    = 32;
    localparam int FIELD_W = 4;
    localparam int NFIELD  = XLEN / FIELD_W;
    localparam int FSEL_W  = $clog2(NFIELD);
    localparam int IMM_W   = 16;
    localparam int OP_W    = 3;
    localparam int SH_W    = $clog2(XLEN);
    localparam int BC_W    = 8;

    // exception register bit positions
    localparam int XER_SO = 0;
    localparam int XER_OV = 1;
    localparam int XER_CA = 2;

    // positions inside one condition field
    localparam int NIB_SO = 0;
    localparam int NIB_EQ = 1;
    localparam int NIB_GT = 2;
    localparam int NIB_LT = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CMPS = 3'd2,
        OP_CMPU = 3'd3,
        OP_SHL  = 3'd4,
        OP_SHR  = 3'd5
    } op_e;

    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            ca;
        logic            ov;
        logic            lt;
        logic            gt;
        logic            eq;
        logic            wr_res;
        logic            wr_ca;
        logic            wr_ov;
        logic            is_cmp;
    } exec_t;

    function automatic logic [XLEN-1:0] ext_imm(input logic [IMM_W-1:0] imm,
                                                input logic sext);
        ext_imm = {{(XLEN-IMM_W){sext & imm[IMM_W-1]}}, imm};
    endfunction

    function automatic logic add_ovf(input logic [XLEN-1:0] a,
                                     input logic [XLEN-1:0] b,
                                     input logic [XLEN-1:0] r);
        add_ovf = (a[XLEN-1] == b[XLEN-1]) && (r[XLEN-1] != a[XLEN-1]);
    endfunction

    function automatic logic sub_ovf(input logic [XLEN-1:0] a,
                                     input logic [XLEN-1:0] b,
                                     input logic [XLEN-1:0] r);
        sub_ovf = (a[XLEN-1] != b[XLEN-1]) && (r[XLEN-1] != a[XLEN-1]);
    endfunction

    function automatic logic [FIELD_W-1:0] make_nib(input logic lt, input logic gt,
                                                    input logic eq, input logic so);
        logic [FIELD_W-1:0] n;
        n         = '0;
        n[NIB_LT] = lt;
        n[NIB_GT] = gt;
        n[NIB_EQ] = eq;
        n[NIB_SO] = so;
        return n;
    endfunction

endpackage

// File: rtl/cfx_exec.sv
module cfx_exec
    import cfx_pkg::*;
(
    input  op_e              op_i,
    input  logic [XLEN-1:0]  a_i,
    input  logic [XLEN-1:0]  b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             imm_sel_i,
    output exec_t            ex_o
);

    logic [XLEN-1:0] opnd;
    logic [XLEN:0]   add_w;
    logic [XLEN:0]   sub_w;
    logic [XLEN:0]   shl_w;
    logic [XLEN:0]   shr_w;
    logic [SH_W-1:0] sh_amt;

    assign opnd   = imm_sel_i ? ext_imm(imm_i, op_i != OP_CMPU) : b_i;
    assign sh_amt = opnd[SH_W-1:0];
    assign add_w  = {1'b0, a_i} + {1'b0, opnd};
    assign sub_w  = {1'b0, a_i} + {1'b0, ~opnd} + (XLEN+1)'(1);
    // bit XLEN of the left shift and bit 0 of the right shift are the last bits out
    assign shl_w  = {1'b0, a_i} << sh_amt;
    assign shr_w  = {a_i, 1'b0} >> sh_amt;

    always_comb begin
        ex_o = '0;
        unique case (op_i)
            OP_ADD: begin
                ex_o.res    = add_w[XLEN-1:0];
                ex_o.ca     = add_w[XLEN];
                ex_o.ov     = add_ovf(a_i, opnd, add_w[XLEN-1:0]);
                ex_o.wr_res = 1'b1;
                ex_o.wr_ca  = 1'b1;
                ex_o.wr_ov  = 1'b1;
            end
            OP_SUB: begin
                ex_o.res    = sub_w[XLEN-1:0];
                ex_o.ca     = sub_w[XLEN];
                ex_o.ov     = sub_ovf(a_i, opnd, sub_w[XLEN-1:0]);
                ex_o.wr_res = 1'b1;
                ex_o.wr_ca  = 1'b1;
                ex_o.wr_ov  = 1'b1;
            end
            OP_SHL: begin
                ex_o.res    = shl_w[XLEN-1:0];
                ex_o.ca     = shl_w[XLEN];
                ex_o.wr_res = 1'b1;
                ex_o.wr_ca  = 1'b1;
            end
            OP_SHR: begin
                ex_o.res    = shr_w[XLEN:1];
                ex_o.ca     = shr_w[0];
                ex_o.wr_res = 1'b1;
                ex_o.wr_ca  = 1'b1;
            end
            OP_CMPS: begin
                ex_o.is_cmp = 1'b1;
                ex_o.lt     = $signed(a_i) < $signed(opnd);
                ex_o.gt     = $signed(a_i) > $signed(opnd);
                ex_o.eq     = a_i == opnd;
            end
            OP_CMPU: begin
                ex_o.is_cmp = 1'b1;
                ex_o.lt     = a_i < opnd;
                ex_o.gt     = a_i > opnd;
                ex_o.eq     = a_i == opnd;
            end
            default: ex_o = '0;
        endcase
        if (!ex_o.is_cmp) begin
            ex_o.lt = ex_o.res[XLEN-1];
            ex_o.gt = !ex_o.res[XLEN-1] && (ex_o.res != '0);
            ex_o.eq = ex_o.res == '0;
        end
    end

endmodule

// File: rtl/cfx_xer_reg.sv
module cfx_xer_reg
    import cfx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en_i,
    input  logic [XLEN-1:0] wr_data_i,
    input  logic            upd_ca_i,
    input  logic            ca_i,
    input  logic            upd_ov_i,
    input  logic            ov_i,
    output logic            so_next_o,
    output logic [XLEN-1:0] xer_o
);

    logic [XLEN-1:0] xer_q;

    // summary overflow as seen by a field written in this same cycle
    assign so_next_o = xer_q[XER_SO] | (upd_ov_i & ov_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            xer_q <= '0;
        end else if (wr_en_i) begin
            xer_q <= wr_data_i;
        end else begin
            if (upd_ov_i) begin
                xer_q[XER_OV] <= ov_i;
                xer_q[XER_SO] <= xer_q[XER_SO] | ov_i;
            end
            if (upd_ca_i) begin
                xer_q[XER_CA] <= ca_i;
            end
        end
    end

    assign xer_o = xer_q;

endmodule

// File: rtl/cfx_cr_file.sv
module cfx_cr_file
    import cfx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic [XLEN-1:0]    wr_data_i,
    input  logic               upd_en_i,
    input  logic [FSEL_W-1:0]  upd_idx_i,
    input  logic [FIELD_W-1:0] upd_nib_i,
    output logic [XLEN-1:0]    cr_o
);

    for (genvar k = 0; k < NFIELD; k++) begin : g_field
        logic [FIELD_W-1:0] fld_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                fld_q <= '0;
            end else if (wr_en_i) begin
                fld_q <= wr_data_i[k*FIELD_W +: FIELD_W];
            end else if (upd_en_i && (upd_idx_i == FSEL_W'(k))) begin
                fld_q <= upd_nib_i;
            end
        end

        assign cr_o[k*FIELD_W +: FIELD_W] = fld_q;
    end

endmodule

// File: rtl/cfx_flag_unit.sv
module cfx_flag_unit
    import cfx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid_i,
    input  logic [2:0]  op_i,
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    input  logic [15:0] imm_i,
    input  logic        imm_sel_i,
    input  logic        record_i,
    input  logic [2:0]  fsel_i,
    input  logic        cr_we_i,
    input  logic [31:0] cr_wdata_i,
    input  logic        xer_we_i,
    input  logic [31:0] xer_wdata_i,
    output logic [31:0] result_o,
    output logic [31:0] cr_o,
    output logic [31:0] xer_o
);

    exec_t              ex;
    logic               so_next;
    logic               cr_upd;
    logic [FSEL_W-1:0]  cr_idx;
    logic [FIELD_W-1:0] cr_nib;
    logic [XLEN-1:0]    result_q;

    cfx_exec u_exec (
        .op_i      (op_e'(op_i)),
        .a_i       (opa_i),
        .b_i       (opb_i),
        .imm_i     (imm_i),
        .imm_sel_i (imm_sel_i),
        .ex_o      (ex)
    );

    cfx_xer_reg u_xer (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (xer_we_i),
        .wr_data_i (xer_wdata_i),
        .upd_ca_i  (op_valid_i & ex.wr_ca),
        .ca_i      (ex.ca),
        .upd_ov_i  (op_valid_i & ex.wr_ov),
        .ov_i      (ex.ov),
        .so_next_o (so_next),
        .xer_o     (xer_o)
    );

    // compares always write their field; arithmetic and shifts only when recorded
    assign cr_upd = op_valid_i & (ex.is_cmp | (record_i & ex.wr_res));
    assign cr_idx = ex.is_cmp ? fsel_i : '0;
    assign cr_nib = make_nib(ex.lt, ex.gt, ex.eq, so_next);

    cfx_cr_file u_cr (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (cr_we_i),
        .wr_data_i (cr_wdata_i),
        .upd_en_i  (cr_upd),
        .upd_idx_i (cr_idx),
        .upd_nib_i (cr_nib),
        .cr_o      (cr_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
        end else if (op_valid_i && ex.wr_res) begin
            result_q <= ex.res;
        end
    end

    assign result_o = result_q;

endmodule

// File: rtl/cfx_flag_chk.sv
module cfx_flag_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid_i,
    input logic [2:0]  op_i,
    input logic        record_i,
    input logic        cr_we_i,
    input logic [31:0] cr_wdata_i,
    input logic        xer_we_i,
    input logic [31:0] xer_wdata_i,
    input logic [31:0] result_o,
    input logic [31:0] cr_o,
    input logic [31:0] xer_o
);

    logic [31:0] cr_prev_q;
    logic [7:0]  fld_chg;
    logic        arith_op;

    always_ff @(posedge clk) cr_prev_q <= cr_o;

    always_comb begin
        for (int k = 0; k < 8; k++) begin
            fld_chg[k] = cr_o[k*4 +: 4] != cr_prev_q[k*4 +: 4];
        end
    end

    assign arith_op = op_valid_i && (op_i == 3'd0 || op_i == 3'd1);

    // R11
    cr_wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        cr_we_i |=> cr_o == $past(cr_wdata_i));

    // R11
    xer_wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        xer_we_i |=> xer_o == $past(xer_wdata_i));

    // R5
    so_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (xer_o[0] && !xer_we_i) |=> xer_o[0]);

    // R10
    byte_cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !xer_we_i |=> $stable(xer_o[31:24]));

    // R8
    one_field_chk: assert property (@(posedge clk) disable iff (rst)
        !cr_we_i |=> $countones(fld_chg) <= 1);

    // R4
    ov_implies_so_chk: assert property (@(posedge clk) disable iff (rst)
        (arith_op && !xer_we_i) |=> (!xer_o[1] || xer_o[0]));

    // R7
    rec_so_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (arith_op && record_i && !cr_we_i && !xer_we_i) |=> cr_o[0] == xer_o[0]);

    // R7
    rec_lt_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (arith_op && record_i && !cr_we_i) |=> cr_o[3] == result_o[31]);

    // R7
    no_record_chk: assert property (@(posedge clk) disable iff (rst)
        (arith_op && !record_i && !cr_we_i) |=> $stable(cr_o));

endmodule

bind cfx_flag_unit cfx_flag_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid_i  (op_valid_i),
    .op_i        (op_i),
    .record_i    (record_i),
    .cr_we_i     (cr_we_i),
    .cr_wdata_i  (cr_wdata_i),
    .xer_we_i    (xer_we_i),
    .xer_wdata_i (xer_wdata_i),
    .result_o    (result_o),
    .cr_o        (cr_o),
    .xer_o       (xer_o)
);

// File: tb/tb_cfx_flag_unit.sv
module tb_cfx_flag_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid_i;
    logic [2:0]  op_i;
    logic [31:0] opa_i, opb_i;
    logic [15:0] imm_i;
    logic        imm_sel_i, record_i;
    logic [2:0]  fsel_i;
    logic        cr_we_i, xer_we_i;
    logic [31:0] cr_wdata_i, xer_wdata_i;
    logic [31:0] result_o, cr_o, xer_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cfx_flag_unit dut (.*);

    // {op[100:98], a[97:66], b[65:34], result[33:2], carry[1], overflow[0]}
    localparam int NVEC = 13;
    localparam logic [100:0] VEC [NVEC] = '{
        {3'd0, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0, 1'b0},
        {3'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1},
        {3'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0},
        {3'd0, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1},
        {3'd1, 32'h00000005, 32'h00000003, 32'h00000002, 1'b1, 1'b0},
        {3'd1, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 1'b0, 1'b0},
        {3'd1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 1'b1},
        {3'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 1'b0, 1'b1},
        {3'd4, 32'h80000001, 32'h00000001, 32'h00000002, 1'b1, 1'b0},
        {3'd5, 32'h00000003, 32'h00000001, 32'h00000001, 1'b1, 1'b0},
        {3'd4, 32'h00000001, 32'h00000000, 32'h00000001, 1'b0, 1'b0},
        {3'd5, 32'h80000000, 32'h0000001F, 32'h00000001, 1'b0, 1'b0},
        {3'd4, 32'h40000000, 32'h00000002, 32'h00000000, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        op_valid_i = 0; op_i = 0; opa_i = 0; opb_i = 0; imm_i = 0; imm_sel_i = 0;
        record_i = 0; fsel_i = 0; cr_we_i = 0; cr_wdata_i = 0; xer_we_i = 0;
        xer_wdata_i = 0;
    endtask

    // drive at negedge, let one posedge pass, return at the next negedge
    task automatic cycle(input bit v, input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] imm, input bit isel,
                         input bit rec, input logic [2:0] fs, input bit crwe,
                         input logic [31:0] crw, input bit xwe, input logic [31:0] xw);
        op_valid_i = v; op_i = op; opa_i = a; opb_i = b; imm_i = imm; imm_sel_i = isel;
        record_i = rec; fsel_i = fs; cr_we_i = crwe; cr_wdata_i = crw;
        xer_we_i = xwe; xer_wdata_i = xw;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic write_regs(input logic [31:0] crw, input logic [31:0] xw);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, crw, 1, xw);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        check(result_o == 0, "R1 result", result_o, 0);
        check(cr_o == 0,     "R1 cr",     cr_o, 0);
        check(xer_o == 0,    "R1 xer",    xer_o, 0);

        // table walk: R2 add, R3 sub, R6 shift, plus R4 overflow and R7 field 0
        for (int i = 0; i < NVEC; i++) begin
            logic [2:0]  vop;
            logic [31:0] va, vb, vr, exp_cr, exp_xer;
            logic        vca, vov;
            string       tag;
            vop = VEC[i][100:98]; va = VEC[i][97:66]; vb = VEC[i][65:34];
            vr  = VEC[i][33:2];   vca = VEC[i][1];    vov = VEC[i][0];
            tag = (vop == 3'd0) ? "R2" : (vop == 3'd1) ? "R3" : "R6";
            write_regs(32'h0, 32'h0);
            cycle(1, vop, va, vb, 0, 0, 1, 0, 0, 0, 0, 0);
            exp_cr  = {28'h0, vr[31], !vr[31] && vr != 0, vr == 0, vov};
            exp_xer = {29'h0, vca, vov, vov};
            check(result_o == vr, {tag, " result"}, result_o, vr);
            check(xer_o == exp_xer, {tag, " R4 xer flags"}, xer_o, exp_xer);
            check(cr_o == exp_cr, {tag, " R7 field0"}, cr_o, exp_cr);
        end

        // R5: summary overflow survives a clean add and is copied into field 0
        write_regs(32'h0, 32'h0);
        cycle(1, 3'd0, 32'h7FFFFFFF, 32'h1, 0, 0, 1, 0, 0, 0, 0, 0);
        cycle(1, 3'd0, 32'h1, 32'h2, 0, 0, 1, 0, 0, 0, 0, 0);
        check(xer_o == 32'h1, "R5 sticky so", xer_o, 32'h1);
        check(cr_o == 32'h5, "R5 R7 field0 so copy", cr_o, 32'h5);

        // R8: compares into selected fields, others untouched
        write_regs(32'h89ABCDEF, 32'h1);
        cycle(1, 3'd2, 32'hFFFFFFFF, 32'h1, 0, 0, 0, 3'd5, 0, 0, 0, 0);
        check(cr_o == 32'h899BCDEF, "R8 signed cmp field5", cr_o, 32'h899BCDEF);
        check(result_o == 32'h3, "R8 result unchanged", result_o, 32'h3);
        check(xer_o == 32'h1, "R8 xer unchanged", xer_o, 32'h1);
        cycle(1, 3'd3, 32'hFFFFFFFF, 32'h1, 0, 0, 0, 3'd2, 0, 0, 0, 0);
        check(cr_o == 32'h899BC5EF, "R8 unsigned cmp field2", cr_o, 32'h899BC5EF);

        // R9: immediate extension
        cycle(1, 3'd2, 32'hFFFFFFFF, 0, 16'hFFFF, 1, 0, 3'd7, 0, 0, 0, 0);
        check(cr_o == 32'h399BC5EF, "R9 sext cmp eq", cr_o, 32'h399BC5EF);
        cycle(1, 3'd3, 32'h0000FFFF, 0, 16'hFFFF, 1, 0, 3'd6, 0, 0, 0, 0);
        check(cr_o == 32'h339BC5EF, "R9 zext cmp eq", cr_o, 32'h339BC5EF);
        cycle(1, 3'd3, 32'h0000FFFE, 0, 16'hFFFF, 1, 0, 3'd1, 0, 0, 0, 0);
        check(cr_o == 32'h339BC59F, "R9 zext cmp lt", cr_o, 32'h339BC59F);
        cycle(1, 3'd0, 32'h1, 32'h12345678, 16'hFFFF, 1, 0, 0, 0, 0, 0, 0);
        check(result_o == 32'h0, "R9 add sext imm", result_o, 32'h0);
        check(cr_o == 32'h339BC59F, "R7 no record", cr_o, 32'h339BC59F);
        check(xer_o == 32'h5, "R9 add imm carry", xer_o, 32'h5);

        // R10: byte count untouched by operations; R6 shift keeps OV/SO
        write_regs(32'h0, 32'hAB000000);
        cycle(1, 3'd0, 32'h7FFFFFFF, 32'h1, 0, 0, 0, 0, 0, 0, 0, 0);
        check(xer_o == 32'hAB000003, "R10 byte count kept", xer_o, 32'hAB000003);
        cycle(1, 3'd4, 32'h80000000, 32'h1, 0, 0, 0, 0, 0, 0, 0, 0);
        check(xer_o == 32'hAB000007, "R6 R10 shift keeps ov", xer_o, 32'hAB000007);
        check(result_o == 32'h0, "R6 shift result", result_o, 32'h0);

        // R11: explicit writes win over a same-cycle overflowing recorded add
        cycle(1, 3'd0, 32'h7FFFFFFF, 32'h1, 0, 0, 1, 0, 1, 32'h11111111, 1, 32'h0);
        check(cr_o == 32'h11111111, "R11 cr write wins", cr_o, 32'h11111111);
        check(xer_o == 32'h0, "R11 xer write wins", xer_o, 32'h0);
        check(result_o == 32'h80000000, "R11 result still updates", result_o, 32'h80000000);

        // R5: after the explicit clear, a clean add leaves SO low
        cycle(1, 3'd0, 32'h1, 32'h1, 0, 0, 1, 0, 0, 0, 0, 0);
        check(cr_o == 32'h11111114, "R5 R7 cleared so", cr_o, 32'h11111114);
        check(xer_o == 32'h0, "R5 xer clear", xer_o, 32'h0);

        // R1: reset again mid-run
        rst = 1;
        @(negedge clk);
        rst = 0;
        check(cr_o == 0 && xer_o == 0 && result_o == 0, "R1 reset again",
              cr_o | xer_o | result_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule